// File: doc/BRIEF.md
# Interrupt Acceptance and Vectoring Unit

This block decides which pending interrupt a small 8-bit processor core takes at the next instruction boundary. It then produces the entry address and the status-flag updates for that interrupt. Hardware request lines are latched as pending bits. Each source has its own enable bit and its own priority level. A hardware source is eligible only while the global interrupt-enable flag is set.

A software break instruction and a table-call-zero instruction both enter through one shared address. The break flag in the status word tells the shared entry code which routine to run: it is set for a break and cleared for a table call. When the unit accepts a hardware interrupt or a break, it pushes the current global-enable and break flags onto a small internal stack and clears the global enable. A return-from-interrupt strobe pops that saved state. Nested service happens only when a handler sets the global enable again.

Top module: `irq_vector_unit`

## Requirements
- R1: When eligible requests at different priority levels are pending, the one with the numerically larger level (from the `irq_lvl` field `[i*PRIO_W +: PRIO_W]`) is accepted.
- R2: Among eligible requests at the same level, the lowest source index is accepted.
- R3: An accept is decided only in a cycle with `boundary` high. `take` rises on the next clock for exactly one clock. The unit makes no decision in the cycle right after an accept. Accepting a hardware interrupt or a break clears `ie_flag` on that same edge.
- R4: A hardware request stays pending while `ie_flag` is clear or its enable bit is clear, and it is accepted once both are set. A set bit in `irq_clr` removes the pending request and wins over a request on the same line in the same cycle.
- R5: If `ie_set` is pulsed inside a handler, a newly pending request is accepted before any return, which nests the service.
- R6: A break request is accepted whatever the state of `ie_flag`, but only when no hardware source is accepted at that boundary. It yields `VEC_SHARED`, sets `brk_flag` and clears `ie_flag`.
- R7: A table-call-zero request yields `VEC_SHARED` and clears `brk_flag`. It leaves `ie_flag` unchanged and saves nothing on the stack.
- R8: Each `reti` pops `{ie_flag, brk_flag}` in last-in first-out order from a stack `STK_D` entries deep (default 4). A `reti` with an empty stack changes nothing, and on overflow the oldest entry is lost.
- R9: Hardware source i is vectored to `VEC_TOP - 2*i`, so the table holds consecutive 16-bit slots going down from the top.
- R10: After reset, `take`, `ie_flag` and `brk_flag` are 0, `take_vec` is 0, and nothing is pending.
- R11: Within one cycle, an accept beats `reti`, which beats `ie_clr`, which beats `ie_set`. A `boundary` that coincides with `reti` accepts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Hardware request pulses, latched as pending |
| irq_en | input | N_SRC | Per-source enable |
| irq_lvl | input | N_SRC*PRIO_W | Per-source priority level, larger wins |
| irq_clr | input | N_SRC | Clear pending request per source |
| brk_req | input | 1 | Software break request, latched |
| tcall0_req | input | 1 | Table-call-zero request, valid with boundary |
| boundary | input | 1 | Instruction-boundary strobe |
| ie_set | input | 1 | Set global interrupt enable |
| ie_clr | input | 1 | Clear global interrupt enable |
| reti | input | 1 | Return-from-interrupt strobe |
| take | output | 1 | One-clock accept pulse |
| take_vec | output | 16 | Entry address of the accepted request |
| ie_flag | output | 1 | Global interrupt-enable flag |
| brk_flag | output | 1 | Break flag of the status word |

## Verification
With a four-source configuration, the arbiter is swept over every pending mask against every assignment of levels. This separates picking by level from picking by index, and it exposes a wrong comparison direction or a wrong tie rule. A second sweep crosses every pending mask with every enable mask at fixed levels, which shows that disabled sources are skipped and stay pending. Directed sequences cover the remaining cases: a break racing a hardware request, table call against break on the shared address, four-deep nesting with mixed break flags unwound by returns, clear against request, and returns that coincide with a boundary.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int          N_SRC      = 8,
  parameter int          PRIO_W     = 2,
  parameter int          STK_D      = 4,
  parameter logic [15:0] VEC_TOP    = 16'hFFFE,
  parameter logic [15:0] VEC_SHARED = 16'hFFC0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         irq_req,
  input  logic [N_SRC-1:0]         irq_en,
  input  logic [N_SRC*PRIO_W-1:0]  irq_lvl,
  input  logic [N_SRC-1:0]         irq_clr,
  input  logic                     brk_req,
  input  logic                     tcall0_req,
  input  logic                     boundary,
  input  logic                     ie_set,
  input  logic                     ie_clr,
  input  logic                     reti,
  output logic                     take,
  output logic [15:0]              take_vec,
  output logic                     ie_flag,
  output logic                     brk_flag
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int DW = $clog2(STK_D + 1);

  logic [N_SRC-1:0]  pend;
  logic              brk_pend;
  logic [1:0]        stk [STK_D];
  logic [DW-1:0]     depth;

  logic              hw_hit;
  logic [IW-1:0]     hw_idx;
  logic [PRIO_W-1:0] best;

  always_comb begin
    hw_hit = 1'b0;
    hw_idx = '0;
    best   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && irq_en[i] &&
          (!hw_hit || irq_lvl[i*PRIO_W +: PRIO_W] > best)) begin
        hw_hit = 1'b1;
        hw_idx = IW'(i);
        best   = irq_lvl[i*PRIO_W +: PRIO_W];
      end
    end
  end

  wire go    = boundary && !reti && !take;
  wire g_hw  = go && ie_flag && hw_hit;
  wire g_brk = go && !g_hw && brk_pend;
  wire g_tc  = go && !g_hw && !brk_pend && tcall0_req;
  wire [N_SRC-1:0] grant = g_hw ? (N_SRC'(1) << hw_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      brk_pend <= 1'b0;
      take     <= 1'b0;
      take_vec <= '0;
      ie_flag  <= 1'b0;
      brk_flag <= 1'b0;
      depth    <= '0;
      for (int k = 0; k < STK_D; k++) stk[k] <= '0;
    end else begin
      pend     <= ((pend & ~grant) | irq_req) & ~irq_clr;
      brk_pend <= (brk_pend & ~g_brk) | brk_req;
      take     <= g_hw || g_brk || g_tc;

      if (g_hw)              take_vec <= VEC_TOP - (16'(hw_idx) << 1);
      else if (g_brk || g_tc) take_vec <= VEC_SHARED;

      if (g_hw || g_brk) begin
        ie_flag  <= 1'b0;
        brk_flag <= g_brk;
        stk[0]   <= {ie_flag, brk_flag};
        for (int k = 1; k < STK_D; k++) stk[k] <= stk[k-1];
        if (depth != DW'(STK_D)) depth <= depth + 1'b1;
      end else if (g_tc) begin
        brk_flag <= 1'b0;
      end else if (reti) begin
        if (depth != '0) begin
          {ie_flag, brk_flag} <= stk[0];
          for (int k = 0; k < STK_D - 1; k++) stk[k] <= stk[k+1];
          stk[STK_D-1] <= '0;
          depth <= depth - 1'b1;
        end
      end else if (ie_clr) begin
        ie_flag <= 1'b0;
      end else if (ie_set) begin
        ie_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
  parameter int          N_SRC      = 8,
  parameter logic [15:0] VEC_TOP    = 16'hFFFE,
  parameter logic [15:0] VEC_SHARED = 16'hFFC0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        take,
  input logic [15:0] take_vec,
  input logic        ie_flag,
  input logic        brk_flag
);
  localparam logic [15:0] VEC_LOW = VEC_TOP - 16'(2 * (N_SRC - 1));

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  assert_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(boundary));

  assert_ie_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_vec != VEC_SHARED) |-> !ie_flag);

  assert_hw_needs_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_vec != VEC_SHARED) |-> $past(ie_flag));

  assert_break_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && brk_flag) |-> (take_vec == VEC_SHARED && !ie_flag));

  assert_table_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_vec != VEC_SHARED) |->
      (!take_vec[0] && take_vec <= VEC_TOP && take_vec >= VEC_LOW));
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
  .N_SRC(N_SRC), .VEC_TOP(VEC_TOP), .VEC_SHARED(VEC_SHARED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .take(take),
  .take_vec(take_vec), .ie_flag(ie_flag), .brk_flag(brk_flag)
);

// File: tb/sim_irq_vector_unit.sv
module sim_irq_vector_unit;
  localparam int          N  = 4;
  localparam logic [15:0] TOP = 16'hFFFE;
  localparam logic [15:0] SH  = 16'hFFC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   irq_req = '0, irq_en = '0, irq_clr = '0;
  logic [2*N-1:0] irq_lvl = '0;
  logic brk_req = 0, tcall0_req = 0, boundary = 0, ie_set = 0, ie_clr = 0, reti = 0;
  logic take, ie_flag, brk_flag;
  logic [15:0] take_vec;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vector_unit #(.N_SRC(N), .PRIO_W(2), .STK_D(4), .VEC_TOP(TOP), .VEC_SHARED(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en), .irq_lvl(irq_lvl),
    .irq_clr(irq_clr), .brk_req(brk_req), .tcall0_req(tcall0_req), .boundary(boundary),
    .ie_set(ie_set), .ie_clr(ie_clr), .reti(reti), .take(take), .take_vec(take_vec),
    .ie_flag(ie_flag), .brk_flag(brk_flag));

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pick(logic [N-1:0] v, logic [2*N-1:0] l);
    int b = -1, bl = -1;
    for (int i = 0; i < N; i++)
      if (v[i] && int'(l[2*i +: 2]) > bl) begin b = i; bl = int'(l[2*i +: 2]); end
    return b;
  endfunction

  task automatic bnd(); boundary = 1; tick(); boundary = 0; endtask
  task automatic do_reti(); reti = 1; tick(); reti = 0; endtask

  task automatic trial(string req, logic [N-1:0] m, logic [N-1:0] e, logic [2*N-1:0] l);
    int w;
    irq_en = e; irq_lvl = l;
    irq_clr = '1; ie_set = 1; tick();
    irq_clr = '0; ie_set = 0; irq_req = m; tick();
    irq_req = '0; bnd();
    w = pick(m & e, l);
    if (w >= 0) begin
      chk(req, take, 1);
      chk(req, take_vec, TOP - 16'(2 * w));
      chk(req, ie_flag, 0);
      tick();
      chk("R3", take, 0);
      do_reti();
      chk("R8", ie_flag, 1);
    end else begin
      chk(req, take, 0);
      chk(req, ie_flag, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R10", take, 0); chk("R10", ie_flag, 0); chk("R10", brk_flag, 0); chk("R10", take_vec, 0);
    rst_n = 1; tick();
    irq_en = '1; irq_lvl = '0;

    // R4: request with global enable clear stays pending
    irq_req = 4'b0100; tick(); irq_req = '0;
    bnd(); chk("R4", take, 0);
    ie_set = 1; tick(); ie_set = 0;
    bnd(); chk("R4", take, 1); chk("R4", take_vec, 16'hFFFA);
    tick(); do_reti(); chk("R8", ie_flag, 1);

    // R4: disabled source stays pending
    irq_en = 4'b1110; irq_req = 4'b0001; tick(); irq_req = '0;
    bnd(); chk("R4", take, 0);
    irq_en = '1; bnd(); chk("R4", take, 1); chk("R9", take_vec, 16'hFFFE);
    tick(); do_reti();

    // R4: clear beats same-cycle request
    irq_req = 4'b0010; irq_clr = 4'b0010; tick(); irq_req = '0; irq_clr = '0;
    bnd(); chk("R4", take, 0); chk("R4", ie_flag, 1);

    // R6: break taken with global enable clear
    ie_clr = 1; tick(); ie_clr = 0;
    brk_req = 1; tick(); brk_req = 0;
    bnd(); chk("R6", take, 1); chk("R6", take_vec, SH); chk("R6", brk_flag, 1); chk("R6", ie_flag, 0);
    tick(); do_reti(); chk("R8", ie_flag, 0); chk("R8", brk_flag, 0);

    // R6: break loses to hardware at the same boundary
    ie_set = 1; tick(); ie_set = 0;
    irq_req = 4'b1000; brk_req = 1; tick(); irq_req = '0; brk_req = 0;
    bnd(); chk("R6", take_vec, 16'hFFF8); chk("R6", brk_flag, 0); chk("R3", ie_flag, 0);
    tick(); chk("R3", take, 0);
    bnd(); chk("R6", take, 1); chk("R6", take_vec, SH); chk("R6", brk_flag, 1);
    tick(); do_reti(); chk("R8", brk_flag, 0); chk("R8", ie_flag, 0);
    do_reti(); chk("R8", ie_flag, 1); chk("R8", brk_flag, 0);

    // R7: table call zero
    tcall0_req = 1; bnd(); tcall0_req = 0;
    chk("R7", take, 1); chk("R7", take_vec, SH); chk("R7", brk_flag, 0); chk("R7", ie_flag, 1);
    tick(); do_reti(); chk("R7", ie_flag, 1);

    // R5 and R8: four-deep nesting with mixed break flags
    brk_req = 1; tick(); brk_req = 0; bnd();
    chk("R6", brk_flag, 1);
    ie_set = 1; tick(); ie_set = 0;
    irq_req = 4'b0001; tick(); irq_req = '0; bnd();
    chk("R5", take, 1); chk("R5", take_vec, 16'hFFFE); chk("R5", brk_flag, 0);
    ie_set = 1; tick(); ie_set = 0;
    brk_req = 1; tick(); brk_req = 0; bnd();
    chk("R5", brk_flag, 1);
    ie_set = 1; tick(); ie_set = 0;
    irq_req = 4'b1000; tick(); irq_req = '0; bnd();
    chk("R5", take_vec, 16'hFFF8);
    tick();
    do_reti(); chk("R8", {ie_flag, brk_flag}, 2'b11);
    do_reti(); chk("R8", {ie_flag, brk_flag}, 2'b10);
    do_reti(); chk("R8", {ie_flag, brk_flag}, 2'b11);
    do_reti(); chk("R8", {ie_flag, brk_flag}, 2'b10);
    ie_clr = 1; tick(); ie_clr = 0;
    do_reti(); chk("R8", ie_flag, 0);

    // R11: precedence
    ie_set = 1; ie_clr = 1; tick(); ie_set = 0; ie_clr = 0;
    chk("R11", ie_flag, 0);
    ie_set = 1; tick(); ie_set = 0;
    irq_req = 4'b0100; tick(); irq_req = '0;
    boundary = 1; reti = 1; tick(); boundary = 0; reti = 0;
    chk("R11", take, 0); chk("R11", ie_flag, 1);
    bnd(); chk("R11", take, 1); chk("R11", take_vec, 16'hFFFA);
    tick(); do_reti();

    // R1, R2, R9: every pending mask against every level assignment
    for (int m = 0; m < 16; m++)
      for (int l = 0; l < 256; l++)
        trial("R1 R2 R9", 4'(m), 4'hF, 8'(l));

    // R4: every pending mask against every enable mask
    for (int m = 0; m < 16; m++)
      for (int e = 0; e < 16; e++)
        trial("R4", 4'(m), 4'(e), 8'b01_11_00_10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule